// File: doc/BRIEF.md
# Flash Program Pause Sequencer

This block sits on the host side of a parallel NOR flash bus. It lets the system pause a flash program operation, and that operation may itself be running inside a suspended erase. While the program is paused, the system can read data elsewhere in the device and then let the program carry on. A pause request makes the block write the suspend command (byte B0h) to the flash. It then holds off all array traffic for a fixed settling time of 15 µs, counted in clock cycles derived from the `CLK_HZ` parameter. Only after that does it accept reads. A continue request makes the block write the resume command (byte 30h). Both commands go to address zero, because the flash accepts them at any address.

While paused, the block remembers the sector of the interrupted program. That sector is the address bits from `SECTOR_LSB` upward, taken from the address given with the pause request. Any array read aimed at that sector is rejected with an error pulse. Reads of other sectors go through. So do reads flagged as alternate space (identification data or the secured sector), whichever sector their address names. A continue request that arrives before the settling time is over, or while a read is on the bus, is held and carried out as soon as possible.

The controller has six states, in `state_q`:
- IDLE waits for a pause request.
- ISSUE_SUSPEND drives the one-cycle suspend write.
- SETTLE counts the settling time.
- SUSPENDED accepts reads and continue requests.
- READ holds the read strobe for `RD_LAT` cycles.
- ISSUE_RESUME drives the one-cycle resume write and returns to IDLE.

The transitions are:
- IDLE to ISSUE_SUSPEND on `susp_req`.
- ISSUE_SUSPEND to SETTLE unconditionally.
- SETTLE to SUSPENDED, or to ISSUE_RESUME if a continue is held, when the count expires.
- SUSPENDED to ISSUE_RESUME on `rsm_req`.
- SUSPENDED to READ on an accepted read.
- READ to SUSPENDED, or to ISSUE_RESUME if a continue is held, when the latency expires.
- ISSUE_RESUME to IDLE unconditionally.

Top module: `fpause_seq`

## Requirements
- R1: After reset, `paused`, `fl_we`, `fl_oe`, `fl_alt`, `susp_ack`, `rsm_ack`, `rd_valid` and `rd_err` are all low.
- R2: A `susp_req` sampled in IDLE produces, in the next cycle, exactly one cycle of `fl_we` with `fl_wdata` equal to 16'h00B0 (command byte B0h in bits 7:0, upper bits zero).
- R3: After the suspend write cycle, `paused` stays low for exactly SETTLE_CYC = ceil(CLK_HZ × 15 µs) cycles, which is 3000 at 200 MHz. `susp_ack` pulses in the last of those cycles, and `paused` is high in the cycle after it.
- R4: A `rsm_req` sampled while SUSPENDED produces, in the next cycle, one cycle of `fl_we` with `fl_wdata` equal to 16'h0030, with `rsm_ack` high in that cycle. In the following cycle `paused` is low.
- R5: A `rsm_req` given during the suspend write or the settling time is held. The resume write follows directly after the last settling cycle, and `paused` never goes high.
- R6: A read accepted while SUSPENDED holds `fl_oe` high for RD_LAT (default 4) cycles, with `fl_addr` equal to the request address. `rd_valid` is high in the last of those cycles, with `rd_data` equal to `fl_rdata`. Afterwards the block is SUSPENDED again.
- R7: A read with `rd_alt` low whose bits [ADDR_W-1:SECTOR_LSB] (default [22:16]) equal those of the `susp_addr` captured with the last accepted pause request gets a `rd_err` pulse in the same cycle, and no read strobe is driven.
- R8: A read with `rd_alt` high is never rejected for its sector, and `fl_alt` is high during its strobe cycles.
- R9: A `rd_req` in any state other than SUSPENDED, or in the same cycle as `rsm_req`, gets a `rd_err` pulse in that cycle and causes no bus activity.
- R10: A `rsm_req` given during a read lets the read finish normally. The resume write follows in the cycle after `rd_valid`.
- R11: `susp_req` outside IDLE and `rsm_req` in IDLE are ignored: no write strobe follows and `paused` keeps its value.
- R12: `fl_we` is never high for two consecutive cycles, and is never high together with `fl_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| susp_req | input | 1 | Pause request, sampled in IDLE |
| susp_addr | input | ADDR_W | Address of the program being paused |
| susp_ack | output | 1 | Pulse in the last settling cycle |
| rsm_req | input | 1 | Continue request |
| rsm_ack | output | 1 | High during the resume write |
| paused | output | 1 | High while reads may be served |
| rd_req | input | 1 | Read request pulse |
| rd_addr | input | ADDR_W | Read address |
| rd_alt | input | 1 | Read targets identification or secured space |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_err | output | 1 | Read rejected |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Flash read data |
| fl_we | output | 1 | Flash write strobe |
| fl_oe | output | 1 | Flash read strobe |
| fl_alt | output | 1 | Flash alternate space select |

## Verification
A wrong state or a miscounted settle timer shows up at the ports within one cycle of the settle window closing. Either `paused` rises a cycle early or late, or a command strobe appears where none belongs. A stale captured sector shows up on the very next read request: it draws `rd_err` for a read that should be served, or lets through a strobe into the interrupted sector. A lost held-resume flag leaves `paused` high after the settle or read completes, instead of producing a B0h-free write of 30h one cycle later.

// File: rtl/fpause_pkg.sv
package fpause_pkg;

    typedef enum logic [2:0] {
        ST_IDLE          = 3'd0,
        ST_ISSUE_SUSPEND = 3'd1,
        ST_SETTLE        = 3'd2,
        ST_SUSPENDED     = 3'd3,
        ST_READ          = 3'd4,
        ST_ISSUE_RESUME  = 3'd5
    } fpause_state_e;

    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;

    // ceil(hz * ns / 1e9), at least one cycle
    function automatic int unsigned settle_cycles(input longint unsigned hz,
                                                  input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/fpause_down_timer.sv
module fpause_down_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpause_sector_guard.sv
module fpause_sector_guard #(
    parameter int unsigned SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEC_W-1:0] cap_sec,
    input  logic [SEC_W-1:0] chk_sec,
    input  logic             chk_alt,
    output logic             hit
);

    logic [SEC_W-1:0] sec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (capture) begin
            sec_q <= cap_sec;
        end
    end

    // alternate-space reads never collide with the array sector
    assign hit = !chk_alt && (chk_sec == sec_q);

endmodule

// File: rtl/fpause_seq.sv
module fpause_seq
    import fpause_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned     SETTLE_NS  = 15_000,
    parameter int unsigned     ADDR_W     = 23,
    parameter int unsigned     DATA_W     = 16,
    parameter int unsigned     SECTOR_LSB = 16,
    parameter int unsigned     RD_LAT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              susp_req,
    input  logic [ADDR_W-1:0] susp_addr,
    output logic              susp_ack,
    input  logic              rsm_req,
    output logic              rsm_ack,
    output logic              paused,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_alt,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_we,
    output logic              fl_oe,
    output logic              fl_alt
);

    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_NS);
    localparam int unsigned SET_W      = ($clog2(SETTLE_CYC) > 0) ? $clog2(SETTLE_CYC) : 1;
    localparam int unsigned RL_W       = ($clog2(RD_LAT) > 0) ? $clog2(RD_LAT) : 1;
    localparam int unsigned SEC_W      = ADDR_W - SECTOR_LSB;
    localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE_CYC - 1);
    localparam logic [RL_W-1:0]  RD_LOAD     = RL_W'(RD_LAT - 1);

    fpause_state_e     state_q, state_d;
    logic              rsm_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_alt_q;
    logic              settle_exp;
    logic              rd_exp;
    logic              sec_hit;
    logic              rd_accept;
    logic              resume_want;

    assign rd_accept   = (state_q == ST_SUSPENDED) && rd_req && !sec_hit && !rsm_req;
    assign resume_want = rsm_pend_q || rsm_req;

    fpause_down_timer #(.W(SET_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_ISSUE_SUSPEND),
        .load_val (SETTLE_LOAD),
        .expired  (settle_exp)
    );

    fpause_down_timer #(.W(RL_W)) u_rdlat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_accept),
        .load_val (RD_LOAD),
        .expired  (rd_exp)
    );

    fpause_sector_guard #(.SEC_W(SEC_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture ((state_q == ST_IDLE) && susp_req),
        .cap_sec (susp_addr[ADDR_W-1:SECTOR_LSB]),
        .chk_sec (rd_addr[ADDR_W-1:SECTOR_LSB]),
        .chk_alt (rd_alt),
        .hit     (sec_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // held resume and latched read request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsm_pend_q <= 1'b0;
            rd_addr_q  <= '0;
            rd_alt_q   <= 1'b0;
        end else begin
            if (state_q == ST_ISSUE_RESUME) begin
                rsm_pend_q <= 1'b0;
            end else if (rsm_req && (state_q == ST_ISSUE_SUSPEND ||
                                     state_q == ST_SETTLE ||
                                     state_q == ST_READ)) begin
                rsm_pend_q <= 1'b1;
            end
            if (rd_accept) begin
                rd_addr_q <= rd_addr;
                rd_alt_q  <= rd_alt;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (susp_req) state_d = ST_ISSUE_SUSPEND;
            ST_ISSUE_SUSPEND: state_d = ST_SETTLE;
            ST_SETTLE:        if (settle_exp)
                                  state_d = resume_want ? ST_ISSUE_RESUME : ST_SUSPENDED;
            ST_SUSPENDED:     if (rsm_req)        state_d = ST_ISSUE_RESUME;
                              else if (rd_accept) state_d = ST_READ;
            ST_READ:          if (rd_exp)
                                  state_d = resume_want ? ST_ISSUE_RESUME : ST_SUSPENDED;
            ST_ISSUE_RESUME:  state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fl_we    = 1'b0;
        fl_oe    = 1'b0;
        fl_alt   = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        susp_ack = 1'b0;
        rsm_ack  = 1'b0;
        paused   = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE_SUSPEND: begin
                fl_we    = 1'b1;
                fl_wdata = DATA_W'(CMD_SUSPEND);
            end
            ST_SETTLE:    susp_ack = settle_exp;
            ST_SUSPENDED: paused = 1'b1;
            ST_READ: begin
                paused   = 1'b1;
                fl_oe    = 1'b1;
                fl_addr  = rd_addr_q;
                fl_alt   = rd_alt_q;
                rd_valid = rd_exp;
            end
            ST_ISSUE_RESUME: begin
                fl_we    = 1'b1;
                fl_wdata = DATA_W'(CMD_RESUME);
                rsm_ack  = 1'b1;
            end
            default: ;
        endcase
        rd_data = fl_rdata;
        rd_err  = rd_req && !rd_accept;
    end

endmodule

// File: rtl/fpause_seq_chk.sv
module fpause_seq_chk
    import fpause_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 200_000_000,
    parameter int unsigned     SETTLE_NS = 15_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_we,
    input logic       fl_oe,
    input logic [7:0] cmd_byte,
    input logic       paused,
    input logic       susp_ack,
    input logic       rsm_ack,
    input logic       rd_valid
);

    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_NS);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    // cycles since the last suspend write, saturating
    logic [CW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= CMAX;
        end else if (fl_we && cmd_byte == CMD_SUSPEND) begin
            since_q <= 1;
        end else if (since_q != CMAX) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> since_q == CW'(SETTLE_CYC + 1));

    p_ack_then_pause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack |=> (paused || rsm_ack));

    p_resume_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_ack |-> (fl_we && cmd_byte == CMD_RESUME));

    p_resume_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_ack |=> (!paused && !fl_we));

    p_strobe_paused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_oe |-> paused);

    p_valid_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> fl_oe);

    p_we_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |=> !fl_we);

    p_we_oe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_oe));

endmodule

bind fpause_seq fpause_seq_chk #(
    .CLK_HZ    (CLK_HZ),
    .SETTLE_NS (SETTLE_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_we    (fl_we),
    .fl_oe    (fl_oe),
    .cmd_byte (fl_wdata[7:0]),
    .paused   (paused),
    .susp_ack (susp_ack),
    .rsm_ack  (rsm_ack),
    .rd_valid (rd_valid)
);

// File: tb/fpause_seq_tb.sv
`timescale 1ns/1ps
module fpause_seq_tb;

    localparam int EXP_SETTLE = 3000; // 200 MHz x 15 us
    localparam int RDL        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        susp_req = 1'b0;
    logic [22:0] susp_addr = '0;
    logic        susp_ack;
    logic        rsm_req = 1'b0;
    logic        rsm_ack;
    logic        paused;
    logic        rd_req = 1'b0;
    logic [22:0] rd_addr = '0;
    logic        rd_alt = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_err;
    logic [22:0] fl_addr;
    logic [15:0] fl_wdata;
    logic [15:0] fl_rdata;
    logic        fl_we;
    logic        fl_oe;
    logic        fl_alt;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign fl_rdata = fl_addr[15:0] ^ 16'hC3A5;

    fpause_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .susp_req(susp_req), .susp_addr(susp_addr), .susp_ack(susp_ack),
        .rsm_req(rsm_req), .rsm_ack(rsm_ack), .paused(paused),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_alt(rd_alt),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_we(fl_we), .fl_oe(fl_oe), .fl_alt(fl_alt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!paused && !fl_we && !fl_oe && !fl_alt, "R1", {paused, fl_we, fl_oe, fl_alt}, 0);
        chk(!susp_ack && !rsm_ack && !rd_valid && !rd_err, "R1",
            {susp_ack, rsm_ack, rd_valid, rd_err}, 0);
    endtask

    task automatic t_suspend(input logic [22:0] a, input bit early_rsm);
        int n;
        int ack_at;
        susp_req = 1'b1; susp_addr = a;
        #1 chk(fl_we == 0, "R2", fl_we, 0);
        tick;
        susp_req = 1'b0;
        if (early_rsm) rsm_req = 1'b1;
        #1 chk(fl_we && fl_wdata == 16'h00B0, "R2", {fl_we, fl_wdata}, 17'h100B0);
        chk(!paused, "R3", paused, 0);
        tick;
        rsm_req = 1'b0;
        #1 chk(!fl_we, "R12", fl_we, 0);
        n = 0; ack_at = -1;
        while (!paused && !fl_we && n < EXP_SETTLE + 10) begin
            if (susp_ack) ack_at = n;
            n++;
            tick;
            #1;
        end
        chk(n == EXP_SETTLE, "R3", n, EXP_SETTLE);
        chk(ack_at == EXP_SETTLE - 1, "R3", ack_at, EXP_SETTLE - 1);
        if (early_rsm) begin
            chk(fl_we && fl_wdata == 16'h0030 && rsm_ack && !paused, "R5",
                {paused, rsm_ack, fl_we, fl_wdata}, 19'h30030);
            tick;
            #1 chk(!paused && !fl_we, "R5", {paused, fl_we}, 0);
        end else begin
            chk(paused, "R3", paused, 1);
        end
    endtask

    task automatic t_resume;
        rsm_req = 1'b1;
        #1 chk(!rsm_ack && paused, "R4", {rsm_ack, paused}, 1);
        tick;
        rsm_req = 1'b0;
        #1 chk(fl_we && fl_wdata == 16'h0030 && rsm_ack, "R4", {rsm_ack, fl_we, fl_wdata}, 18'h30030);
        tick;
        #1 chk(!paused && !fl_we, "R4", {paused, fl_we}, 0);
    endtask

    task automatic t_read(input logic [22:0] a, input bit alt);
        rd_req = 1'b1; rd_addr = a; rd_alt = alt;
        #1 chk(!rd_err, "R6", rd_err, 0);
        tick;
        rd_req = 1'b0;
        #1;
        for (int i = 0; i < RDL; i++) begin
            chk(fl_oe && fl_addr == a, "R6", {fl_oe, fl_addr}, {1'b1, a});
            chk(fl_alt == alt, "R8", fl_alt, alt);
            chk(rd_valid == (i == RDL - 1), "R6", rd_valid, (i == RDL - 1));
            if (i == RDL - 1)
                chk(rd_data == (a[15:0] ^ 16'hC3A5), "R6", rd_data, a[15:0] ^ 16'hC3A5);
            tick;
            #1;
        end
        chk(!fl_oe && paused, "R6", {fl_oe, paused}, 1);
    endtask

    task automatic t_blocked(input logic [22:0] a);
        rd_req = 1'b1; rd_addr = a; rd_alt = 1'b0;
        #1 chk(rd_err, "R7", rd_err, 1);
        tick;
        rd_req = 1'b0;
        #1 chk(!fl_oe && paused, "R7", {fl_oe, paused}, 1);
    endtask

    task automatic t_idle_ignores;
        rsm_req = 1'b1;
        rd_req = 1'b1; rd_addr = 23'h05_1234;
        #1 chk(rd_err, "R9", rd_err, 1);
        tick;
        rsm_req = 1'b0; rd_req = 1'b0;
        #1 chk(!fl_we && !fl_oe && !paused, "R11", {fl_we, fl_oe, paused}, 0);
        tick;
        #1 chk(!fl_we && !paused, "R11", {fl_we, paused}, 0);
    endtask

    task automatic t_suspended_ignores_susp;
        susp_req = 1'b1;
        tick;
        susp_req = 1'b0;
        #1 chk(!fl_we && paused, "R11", {fl_we, paused}, 1);
        tick;
        #1 chk(!fl_we && paused, "R11", {fl_we, paused}, 1);
    endtask

    task automatic t_read_with_resume;
        rd_req = 1'b1; rd_addr = 23'h05_1234; rd_alt = 1'b0;
        rsm_req = 1'b1;
        #1 chk(rd_err, "R9", rd_err, 1);
        tick;
        rd_req = 1'b0; rsm_req = 1'b0;
        #1 chk(fl_we && !fl_oe && fl_wdata == 16'h0030, "R9", {fl_we, fl_oe, fl_wdata}, 18'h20030);
        tick;
        #1 chk(!paused, "R4", paused, 0);
    endtask

    task automatic t_resume_during_read(input logic [22:0] a);
        rd_req = 1'b1; rd_addr = a; rd_alt = 1'b0;
        tick;
        rd_req = 1'b0; rsm_req = 1'b1;
        #1 chk(fl_oe && !fl_we, "R10", {fl_oe, fl_we}, 2);
        tick;
        rsm_req = 1'b0;
        #1;
        for (int i = 1; i < RDL; i++) begin
            chk(fl_oe && rd_valid == (i == RDL - 1), "R10", {fl_oe, rd_valid}, {1'b1, (i == RDL - 1)});
            tick;
            #1;
        end
        chk(fl_we && fl_wdata == 16'h0030 && !fl_oe, "R10", {fl_we, fl_oe, fl_wdata}, 18'h20030);
        tick;
        #1 chk(!paused && !fl_we, "R10", {paused, fl_we}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset;
        rst_n = 1'b1;
        tick;
        t_idle_ignores;
        t_suspend(23'h1A_2345, 1'b0);
        t_blocked(23'h1A_0010);
        t_read(23'h05_1234, 1'b0);
        t_read(23'h1A_0004, 1'b1);
        t_suspended_ignores_susp;
        t_read_with_resume;
        t_suspend(23'h05_0000, 1'b1);
        t_suspend(23'h05_0000, 1'b0);
        t_blocked(23'h05_1234);
        t_read(23'h1A_0010, 1'b0);
        t_resume_during_read(23'h33_00F0);
        t_suspend(23'h22_0000, 1'b0);
        t_resume;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule